// File: doc/BRIEF.md
# Ring Memory Access Node

This block is one stop on a one-way packet ring that joins up to sixteen processing nodes. On every clock it takes one packet slot from its upstream neighbour and hands one slot to its downstream neighbour through a single output register. Packets aimed at this node are decoded and turned into actions on a local 16-bit memory port. These actions are address setup, write, read with an automatic reply, delivery of a read reply, and an indirect write that waits for the local processor's consent. Slots that this node empties, or that arrive empty, can carry a packet that the local processor wants to send.

A broadcast flag lets one packet set the address or write memory on every other node as it travels round the ring. The node that sent it takes it off when it comes back. Direct operations never involve the local processor. An indirect write is parked in a one-entry holding buffer until the processor accepts it. While that buffer is occupied, the node sends nothing of its own.

Top module: `ring_node`

## Requirements
- R1: A slot is 29 bits: bit 28 valid, bits 27:24 destination node, bits 23:20 source node, bits 19:17 function, bit 16 broadcast, bits 15:0 data. A valid packet that this node does not consume appears unchanged on `ring_out` one clock later. An empty input slot with no injection gives an all-zero output slot.
- R2: Function 0 (address), addressed to this node and not broadcast, loads data bits ADDR_W-1:0 into the node's word address register. The slot is consumed, so the output is empty.
- R3: Function 1 (direct write), addressed to this node, writes the data to the word address register's location in the same clock and consumes the slot.
- R4: Function 2 (direct read), addressed to this node, reads the word address register's location. On the next clock the same slot carries a reply with destination = the requester, source = NODE_ID, function 3, broadcast 0, data = the memory word.
- R5: Function 3 (read reply), addressed to this node, is consumed. On the next clock `rsp_valid_o` pulses high for one cycle with the reply's source and data.
- R6: A broadcast packet whose source is another node performs function 0 or 1 here and is forwarded unchanged. A broadcast packet whose source is NODE_ID is removed and has no memory effect.
- R7: Function 4 (indirect write), addressed to this node while the holding buffer is empty, is consumed. From the next clock `ind_valid_o` shows it with its source and data. Memory is not written until it is accepted.
- R8: When `ind_accept_i` is high while the buffer holds a packet, its data is written to the word address that was current when it was captured, and the buffer empties on the next clock. If a ring read or write uses the memory port in that cycle, the write waits.
- R9: A function 4 packet addressed to this node that arrives while the buffer is occupied is forwarded unchanged and leaves the buffer as it was.
- R10: `inj_grant_o` is high only when `inj_req_i` is high, the input slot is empty or consumed, no read reply needs the slot, and the buffer is empty. The granted packet appears on the next clock with source = NODE_ID.
- R11: After reset the output slot is empty, `ind_valid_o` and `rsp_valid_o` are low, and the word address register is zero.
- R12: Functions 5 to 7 addressed to this node are consumed with no memory effect. Broadcast packets with a function other than 0 or 1 do nothing here and are forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in_i | input | 29 | Slot from upstream node |
| ring_out_o | output | 29 | Registered slot to downstream node |
| inj_req_i | input | 1 | Local processor wants to send |
| inj_dst_i | input | 4 | Destination of local packet |
| inj_fn_i | input | 3 | Function of local packet |
| inj_bc_i | input | 1 | Broadcast flag of local packet |
| inj_data_i | input | 16 | Data of local packet |
| inj_grant_o | output | 1 | Local packet takes this clock's slot |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, same cycle |
| ind_valid_o | output | 1 | Indirect write waiting for accept |
| ind_src_o | output | 4 | Sender of waiting indirect write |
| ind_data_o | output | 16 | Data of waiting indirect write |
| ind_accept_i | input | 1 | Processor accepts the waiting write |
| rsp_valid_o | output | 1 | Read reply delivered |
| rsp_src_o | output | 4 | Node that produced the reply |
| rsp_data_o | output | 16 | Reply data |

## Verification
The bench targets a broadcast returning to its own sender. A node that failed to strip it would let it circle forever, or write its own memory. It also checks that an accept arriving in the same cycle as a ring write waits, rather than overwriting the ring's data or dropping the indirect word. It confirms that a second indirect write meets a full buffer and is forwarded, not lost. Injection is probed against pass-through traffic, a read reply and a held buffer; a wrong arbiter would overwrite a live slot or send while stalled.

// File: rtl/ringnode_pkg.sv
package ringnode_pkg;
  localparam int NODE_W = 4;
  localparam int FN_W   = 3;
  localparam int DATA_W = 16;
  localparam int CTRL_W = 1 + 2*NODE_W + FN_W + 1;
  localparam int PKT_W  = CTRL_W + DATA_W;

  localparam logic [FN_W-1:0] FN_ADDR = 3'd0;
  localparam logic [FN_W-1:0] FN_DWR  = 3'd1;
  localparam logic [FN_W-1:0] FN_DRD  = 3'd2;
  localparam logic [FN_W-1:0] FN_RESP = 3'd3;
  localparam logic [FN_W-1:0] FN_IWR  = 3'd4;

  typedef struct packed {
    logic              vld;
    logic [NODE_W-1:0] dst;
    logic [NODE_W-1:0] src;
    logic [FN_W-1:0]   fn;
    logic              bc;
    logic [DATA_W-1:0] data;
  } pkt_t;

  function automatic pkt_t mk_pkt(input logic [NODE_W-1:0] d,
                                  input logic [NODE_W-1:0] s,
                                  input logic [FN_W-1:0]   f,
                                  input logic              b,
                                  input logic [DATA_W-1:0] x);
    pkt_t p;
    p.vld  = 1'b1;
    p.dst  = d;
    p.src  = s;
    p.fn   = f;
    p.bc   = b;
    p.data = x;
    return p;
  endfunction
endpackage

// File: rtl/rn_decode.sv
module rn_decode import ringnode_pkg::*; #(
  parameter logic [NODE_W-1:0] NODE_ID = 4'd5
) (
  input  logic              vld,
  input  logic [NODE_W-1:0] dst,
  input  logic [NODE_W-1:0] src,
  input  logic [FN_W-1:0]   fn,
  input  logic              bc,
  input  logic              hold_full,
  output logic              hit_addr,
  output logic              hit_dwr,
  output logic              hit_drd,
  output logic              hit_resp,
  output logic              hit_iwr,
  output logic              consume
);
  logic for_me, bc_foreign, bc_home, iwr_blocked;

  assign for_me      = vld && !bc && (dst == NODE_ID);
  assign bc_foreign  = vld && bc && (src != NODE_ID);
  assign bc_home     = vld && bc && (src == NODE_ID);
  assign iwr_blocked = for_me && (fn == FN_IWR) && hold_full;

  assign hit_addr = (for_me || bc_foreign) && (fn == FN_ADDR);
  assign hit_dwr  = (for_me || bc_foreign) && (fn == FN_DWR);
  assign hit_drd  = for_me && (fn == FN_DRD);
  assign hit_resp = for_me && (fn == FN_RESP);
  assign hit_iwr  = for_me && (fn == FN_IWR) && !hold_full;
  assign consume  = (for_me && !iwr_blocked) || bc_home;
endmodule

// File: rtl/rn_hold.sv
module rn_hold import ringnode_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [NODE_W-1:0] cap_src,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              accept,
  input  logic              port_busy,
  output logic              valid,
  output logic [NODE_W-1:0] h_src,
  output logic [DATA_W-1:0] h_data,
  output logic [ADDR_W-1:0] h_addr,
  output logic              wr_fire
);
  assign wr_fire = valid && accept && !port_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      h_src  <= '0;
      h_data <= '0;
      h_addr <= '0;
    end else if (capture) begin
      valid  <= 1'b1;
      h_src  <= cap_src;
      h_data <= cap_data;
      h_addr <= cap_addr;
    end else if (wr_fire) begin
      valid  <= 1'b0;
    end
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !wr_fire) |=> (valid && $stable(h_data) && $stable(h_addr))); // R7
  AST_CAPTURE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !valid); // R9
  AST_DRAIN_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !valid); // R8
endmodule

// File: rtl/rn_arb.sv
module rn_arb (
  input  logic in_vld,
  input  logic consume,
  input  logic rsp_need,
  input  logic hold_full,
  input  logic inj_req,
  output logic slot_free,
  output logic grant
);
  assign slot_free = !in_vld || consume;
  assign grant     = inj_req && slot_free && !rsp_need && !hold_full;
endmodule

// File: rtl/ring_node.sv
module ring_node import ringnode_pkg::*; #(
  parameter logic [NODE_W-1:0] NODE_ID = 4'd5,
  parameter int                ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PKT_W-1:0]  ring_in_i,
  output logic [PKT_W-1:0]  ring_out_o,
  input  logic              inj_req_i,
  input  logic [NODE_W-1:0] inj_dst_i,
  input  logic [FN_W-1:0]   inj_fn_i,
  input  logic              inj_bc_i,
  input  logic [DATA_W-1:0] inj_data_i,
  output logic              inj_grant_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ind_valid_o,
  output logic [NODE_W-1:0] ind_src_o,
  output logic [DATA_W-1:0] ind_data_o,
  input  logic              ind_accept_i,
  output logic              rsp_valid_o,
  output logic [NODE_W-1:0] rsp_src_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  pkt_t rin, nxt, out_q;
  logic [ADDR_W-1:0] addr_q, hold_addr;
  logic hit_addr, hit_dwr, hit_drd, hit_resp, hit_iwr, consume;
  logic hold_full, wr_fire, port_busy, slot_free;

  assign rin = pkt_t'(ring_in_i);

  rn_decode #(.NODE_ID(NODE_ID)) u_dec (
    .vld(rin.vld), .dst(rin.dst), .src(rin.src), .fn(rin.fn), .bc(rin.bc),
    .hold_full(hold_full), .hit_addr(hit_addr), .hit_dwr(hit_dwr),
    .hit_drd(hit_drd), .hit_resp(hit_resp), .hit_iwr(hit_iwr), .consume(consume)
  );

  assign port_busy = hit_dwr || hit_drd;

  rn_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(hit_iwr), .cap_src(rin.src),
    .cap_data(rin.data), .cap_addr(addr_q), .accept(ind_accept_i),
    .port_busy(port_busy), .valid(hold_full), .h_src(ind_src_o),
    .h_data(ind_data_o), .h_addr(hold_addr), .wr_fire(wr_fire)
  );

  rn_arb u_arb (
    .in_vld(rin.vld), .consume(consume), .rsp_need(hit_drd),
    .hold_full(hold_full), .inj_req(inj_req_i),
    .slot_free(slot_free), .grant(inj_grant_o)
  );

  assign ind_valid_o = hold_full;

  // memory port: ring traffic first, accepted indirect write otherwise
  assign mem_re_o    = hit_drd;
  assign mem_we_o    = hit_dwr || wr_fire;
  assign mem_addr_o  = port_busy ? addr_q : hold_addr;
  assign mem_wdata_o = hit_dwr ? rin.data : ind_data_o;

  always_comb begin
    if (hit_drd)
      nxt = mk_pkt(rin.src, NODE_ID, FN_RESP, 1'b0, mem_rdata_i);
    else if (inj_grant_o)
      nxt = mk_pkt(inj_dst_i, NODE_ID, inj_fn_i, inj_bc_i, inj_data_i);
    else if (slot_free)
      nxt = '0;
    else
      nxt = rin;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q       <= '0;
      addr_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_src_o   <= '0;
      rsp_data_o  <= '0;
    end else begin
      out_q       <= nxt;
      rsp_valid_o <= hit_resp;
      if (hit_addr) addr_q <= rin.data[ADDR_W-1:0];
      if (hit_resp) begin
        rsp_src_o  <= rin.src;
        rsp_data_o <= rin.data;
      end
    end
  end

  assign ring_out_o = out_q;

  AST_ONE_PORT_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R8
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rin.vld && !consume) |=> (ring_out_o == $past(ring_in_i))); // R1
  AST_REPLY_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_drd |=> (out_q.vld && out_q.fn == FN_RESP && out_q.dst == $past(rin.src))); // R4
  AST_NO_SEND_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ind_valid_o |-> !inj_grant_o); // R10
  AST_GRANT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    inj_grant_o |=> (out_q.vld && out_q.src == NODE_ID)); // R10
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_resp |=> rsp_valid_o); // R5
endmodule

// File: tb/sim_ring_node.sv
module sim_ring_node;
  localparam int AW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [28:0] ring_in, ring_out;
  logic inj_req = 1'b0, inj_bc = 1'b0, inj_grant;
  logic [3:0] inj_dst = '0;
  logic [2:0] inj_fn = '0;
  logic [15:0] inj_data = '0;
  logic [AW-1:0] mem_addr;
  logic mem_we, mem_re, ind_valid, ind_accept = 1'b0, rsp_valid;
  logic [15:0] mem_wdata, mem_rdata, ind_data, rsp_data;
  logic [3:0] ind_src, rsp_src;
  logic [15:0] bmem [256];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign mem_rdata = bmem[mem_addr];
  always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

  ring_node #(.NODE_ID(4'd5), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ring_in_i(ring_in), .ring_out_o(ring_out),
    .inj_req_i(inj_req), .inj_dst_i(inj_dst), .inj_fn_i(inj_fn), .inj_bc_i(inj_bc),
    .inj_data_i(inj_data), .inj_grant_o(inj_grant), .mem_addr_o(mem_addr),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .ind_valid_o(ind_valid), .ind_src_o(ind_src),
    .ind_data_o(ind_data), .ind_accept_i(ind_accept), .rsp_valid_o(rsp_valid),
    .rsp_src_o(rsp_src), .rsp_data_o(rsp_data)
  );

  // slot layout: valid | dst | src | function | broadcast | data
  function automatic logic [28:0] pk(input logic [3:0] d, input logic [3:0] s,
                                     input logic [2:0] f, input logic b,
                                     input logic [15:0] x);
    return {1'b1, d, s, f, b, x};
  endfunction

  localparam int NV = 14;
  localparam logic [57:0] VEC [NV] = '{
    {29'h0, 29'h0},                                             // R1 empty
    {pk(4'd3,4'd7,3'd1,1'b0,16'h1234), pk(4'd3,4'd7,3'd1,1'b0,16'h1234)}, // R1 through
    {pk(4'd5,4'd7,3'd0,1'b0,16'h0010), 29'h0},                   // R2 address
    {pk(4'd5,4'd7,3'd1,1'b0,16'hBEEF), 29'h0},                   // R3 write
    {pk(4'd5,4'd9,3'd2,1'b0,16'h0000), pk(4'd9,4'd5,3'd3,1'b0,16'hBEEF)}, // R4 read
    {pk(4'd0,4'd2,3'd0,1'b1,16'h0020), pk(4'd0,4'd2,3'd0,1'b1,16'h0020)}, // R6 bc addr
    {pk(4'd0,4'd2,3'd1,1'b1,16'h5A5A), pk(4'd0,4'd2,3'd1,1'b1,16'h5A5A)}, // R6 bc write
    {pk(4'd5,4'd9,3'd2,1'b0,16'h0000), pk(4'd9,4'd5,3'd3,1'b0,16'h5A5A)}, // R6 effect
    {pk(4'd0,4'd5,3'd1,1'b1,16'h1111), 29'h0},                   // R6 own bc stripped
    {pk(4'd5,4'd9,3'd2,1'b0,16'h0000), pk(4'd9,4'd5,3'd3,1'b0,16'h5A5A)}, // R6 no write
    {pk(4'd5,4'd7,3'd6,1'b0,16'hFFFF), 29'h0},                   // R12 unused fn
    {pk(4'd0,4'd3,3'd2,1'b1,16'h0000), pk(4'd0,4'd3,3'd2,1'b1,16'h0000)}, // R12 bc read
    {pk(4'd5,4'd9,3'd2,1'b0,16'h0000), pk(4'd9,4'd5,3'd3,1'b0,16'h5A5A)}, // R12 no effect
    {pk(4'd5,4'd12,3'd3,1'b0,16'h7777), 29'h0}                   // R5 reply consumed
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 16'hA500 ^ 16'(i);
    ring_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R11 out empty", 32'(ring_out), 32'h0);
    chk("R11 ind_valid", 32'(ind_valid), 32'h0);
    chk("R11 rsp_valid", 32'(rsp_valid), 32'h0);
    ring_in = pk(4'd5, 4'd9, 3'd2, 1'b0, 16'h0); step;
    chk("R11 address zero", 32'(ring_out), 32'(pk(4'd9, 4'd5, 3'd3, 1'b0, 16'hA500)));

    for (int v = 0; v < NV; v++) begin
      ring_in = VEC[v][57:29];
      step;
      if (ring_out !== VEC[v][28:0]) begin
        fails++;
        $display("FAIL R1..R12 vector %0d: actual %h expected %h", v, ring_out, VEC[v][28:0]);
      end
      checks++;
    end
    chk("R5 rsp_valid", 32'(rsp_valid), 32'h1);
    chk("R5 rsp_src", 32'(rsp_src), 32'd12);
    chk("R5 rsp_data", 32'(rsp_data), 32'h7777);
    ring_in = '0; step;
    chk("R5 single pulse", 32'(rsp_valid), 32'h0);

    // R7 indirect capture
    ring_in = pk(4'd5, 4'd7, 3'd0, 1'b0, 16'h0030); step;
    ring_in = pk(4'd5, 4'd4, 3'd4, 1'b0, 16'hCAFE); step;
    chk("R7 slot consumed", 32'(ring_out), 32'h0);
    chk("R7 ind_valid", 32'(ind_valid), 32'h1);
    chk("R7 ind_src", 32'(ind_src), 32'd4);
    chk("R7 ind_data", 32'(ind_data), 32'hCAFE);
    ring_in = pk(4'd5, 4'd7, 3'd0, 1'b0, 16'h0040); step;
    chk("R7 no write before accept", 32'(bmem[8'h30]), 32'hA530);

    // R10 no injection while held
    ring_in = '0; inj_req = 1'b1; inj_dst = 4'd3; inj_fn = 3'd1; inj_data = 16'h2468;
    #1 chk("R10 grant blocked by hold", 32'(inj_grant), 32'h0);
    step;
    chk("R10 slot stays empty", 32'(ring_out), 32'h0);
    inj_req = 1'b0;

    // R9 second indirect forwarded
    ring_in = pk(4'd5, 4'd6, 3'd4, 1'b0, 16'h1357); step;
    chk("R9 forwarded", 32'(ring_out), 32'(pk(4'd5, 4'd6, 3'd4, 1'b0, 16'h1357)));
    chk("R9 buffer unchanged", 32'(ind_data), 32'hCAFE);

    // R8 accept deferred by ring write, then taken
    ring_in = pk(4'd5, 4'd7, 3'd1, 1'b0, 16'h0101); ind_accept = 1'b1; step;
    chk("R8 ring write wins", 32'(bmem[8'h40]), 32'h0101);
    chk("R8 indirect deferred", 32'(bmem[8'h30]), 32'hA530);
    chk("R8 still held", 32'(ind_valid), 32'h1);
    ring_in = '0; step;
    chk("R8 indirect written", 32'(bmem[8'h30]), 32'hCAFE);
    chk("R8 buffer empty", 32'(ind_valid), 32'h0);
    ind_accept = 1'b0;

    // R10 injection arbitration
    inj_req = 1'b1;
    #1 chk("R10 grant on empty slot", 32'(inj_grant), 32'h1);
    step;
    chk("R10 injected packet", 32'(ring_out), 32'(pk(4'd3, 4'd5, 3'd1, 1'b0, 16'h2468)));
    ring_in = pk(4'd3, 4'd7, 3'd1, 1'b0, 16'h0001);
    #1 chk("R10 ring traffic first", 32'(inj_grant), 32'h0);
    step;
    chk("R10 traffic kept", 32'(ring_out), 32'(pk(4'd3, 4'd7, 3'd1, 1'b0, 16'h0001)));
    ring_in = pk(4'd5, 4'd9, 3'd2, 1'b0, 16'h0);
    #1 chk("R10 reply wins slot", 32'(inj_grant), 32'h0);
    step;
    chk("R4 reply after write", 32'(ring_out), 32'(pk(4'd9, 4'd5, 3'd3, 1'b0, 16'h0101)));
    ring_in = pk(4'd5, 4'd7, 3'd1, 1'b0, 16'h0202);
    #1 chk("R10 grant on consumed slot", 32'(inj_grant), 32'h1);
    step;
    chk("R10 injected into consumed", 32'(ring_out), 32'(pk(4'd3, 4'd5, 3'd1, 1'b0, 16'h2468)));
    chk("R3 write with injection", 32'(bmem[8'h40]), 32'h0202);
    inj_req = 1'b0; ring_in = '0;
    step;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule